// File: doc/BRIEF.md
# Nesting Loop Counter with Count Stack

This block keeps the iteration count of the active hardware loop in a 14-bit down counter. A four-entry stack sits behind the counter and holds the counts of the outer loops that are waiting, so loops can nest. Software loads the true trip count N. The counter-expired flag `ce_o` is high when the counter holds 1. A loop-end test of that flag decrements the counter, so the loop body runs exactly N times.

When a normal load arrives while the counter holds a live count, the live count is pushed onto the stack. When a test finds `ce_o` high, the stack is popped so that the outer loop resumes with its own count. An overwrite load replaces the count and pushes nothing. A manual pop serves an early exit from a loop. The count can be read at any time without disturbing it. Instruction decode sits outside the block: the block only sees one strobe per operation.

Top module: `loop_cnt_top`

## Requirements
- R1: When `load_i` or `ovr_load_i` is high, the counter takes `data_i[13:0]` at the clock edge and becomes valid. Loads take priority over tests and pops.
- R2: `ce_o` is high exactly when the counter is valid and equals 1. After a load of N, the Nth `test_dec_i` finds `ce_o` high.
- R3: A `test_dec_i` (decrementing test) with `ce_o` low decrements the counter, and a counter at 0 stays at 0. A `test_nodec_i` with `ce_o` low leaves the counter unchanged. If both strobes are high, the decrementing test applies.
- R4: `rd_data_o` always equals the counter zero-extended to 16 bits, so bits 15:14 read as 0. Reading has no side effect.
- R5: A `load_i` while the counter is valid pushes the old count onto the stack. The stack holds up to 4 entries in last-in, first-out order.
- R6: A test (either strobe) that finds `ce_o` high pops the stack top into the counter. If the stack is empty, the counter becomes invalid instead: it is decremented for `test_dec_i`, unchanged for `test_nodec_i`, and `ce_o` stays low.
- R7: `pop_i` alone moves the stack top into the counter. On an empty stack it leaves the counter value unchanged and marks the counter invalid.
- R8: No push takes place while the counter is invalid, which is the case after reset and after the empty-stack case of R6 or R7.
- R9: `stk_empty_o` is high exactly when the stack holds no entry. After reset it is high and the counter reads 0.
- R10: `ovr_load_i` replaces the counter without pushing. If `ovr_load_i` and `load_i` are both high, the overwrite applies.
- R11: A push onto a full stack drops the oldest entry and sets `stk_ovf_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Load data; bits 13:0 are used |
| load_i | input | 1 | Load, pushing the old count if valid |
| ovr_load_i | input | 1 | Overwrite load, never pushes |
| test_dec_i | input | 1 | Expired test with decrement (loop end, jump) |
| test_nodec_i | input | 1 | Expired test without decrement |
| pop_i | input | 1 | Manual stack pop |
| rd_data_o | output | 16 | Counter value, zero-extended |
| ce_o | output | 1 | Counter expired |
| stk_empty_o | output | 1 | Count stack holds no entry |
| stk_ovf_o | output | 1 | Sticky stack overflow |

## Verification
The checker asserts on every cycle the rules that depend only on the ports: `ce_o` only at a count of 1, the zero upper read bits, the load value, decrement and hold on tests, stack status unchanged by an overwrite, an empty-stack pop that keeps the value, and overflow stickiness. Stack ordering, the rule that no push happens while the counter is invalid, and the choice of the dropped entry on overflow depend on history several operations deep. Only the bench's scenarios show these, where nested loads are unwound by pops and tests and compared with a queue-based model.

// File: rtl/loop_cnt_pkg.sv
package loop_cnt_pkg;
  localparam int unsigned CNT_W_DEF = 14;
  localparam int unsigned BUS_W_DEF = 16;
  localparam int unsigned DEPTH_DEF = 4;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_OVR,
    OP_TEST,
    OP_POP
  } cnt_op_e;
endpackage

// File: rtl/loop_cnt_stack.sv
module loop_cnt_stack #(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [OCC_W-1:0] occ_q;
  logic             full, do_pop;

  assign ptr_inc = (ptr_q == PTR_MAX) ? '0 : ptr_q + PTR_W'(1);
  assign ptr_dec = (ptr_q == '0) ? PTR_MAX : ptr_q - PTR_W'(1);
  assign full    = (occ_q == OCC_MAX);
  assign empty_o = (occ_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign top_o   = mem_q[ptr_dec];

  // circular slots: when full, slot at ptr holds the oldest entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= '0;
      else if (push_i && ptr_q == PTR_W'(i))     mem_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      occ_q <= '0;
      ovf_o <= 1'b0;
    end else if (push_i) begin
      ptr_q <= ptr_inc;
      if (full) ovf_o <= 1'b1;
      else      occ_q <= occ_q + OCC_W'(1);
    end else if (do_pop) begin
      ptr_q <= ptr_dec;
      occ_q <= occ_q - OCC_W'(1);
    end
  end
endmodule

// File: rtl/loop_cnt_reg.sv
module loop_cnt_reg
  import loop_cnt_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_op_e      op_i,
  input  logic         dec_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] stk_top_i,
  input  logic         stk_empty_i,
  output logic [W-1:0] cnt_o,
  output logic         vld_o,
  output logic         ce_o
);
  logic [W-1:0] cnt_q, cnt_d, cnt_dec;
  logic         vld_q, vld_d;

  assign ce_o    = vld_q && (cnt_q == W'(1));
  assign cnt_dec = (cnt_q == '0) ? cnt_q : cnt_q - W'(1);
  assign cnt_o   = cnt_q;
  assign vld_o   = vld_q;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    unique case (op_i)
      OP_LOAD, OP_OVR: begin
        cnt_d = load_val_i;
        vld_d = 1'b1;
      end
      OP_TEST: begin
        if (ce_o) begin
          if (!stk_empty_i) begin
            cnt_d = stk_top_i;
            vld_d = 1'b1;
          end else begin
            vld_d = 1'b0;
            if (dec_i) cnt_d = cnt_dec;
          end
        end else if (dec_i) begin
          cnt_d = cnt_dec;
        end
      end
      OP_POP: begin
        if (!stk_empty_i) begin
          cnt_d = stk_top_i;
          vld_d = 1'b1;
        end else begin
          vld_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end
endmodule

// File: rtl/loop_cnt_top.sv
module loop_cnt_top
  import loop_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned BUS_W = BUS_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] data_i,
  input  logic             load_i,
  input  logic             ovr_load_i,
  input  logic             test_dec_i,
  input  logic             test_nodec_i,
  input  logic             pop_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             ce_o,
  output logic             stk_empty_o,
  output logic             stk_ovf_o
);
  localparam int unsigned PAD_W = BUS_W - CNT_W;

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt, stk_top;
  logic             vld, push, pop_req;
  logic             unused_hi;

  assign unused_hi = ^data_i[BUS_W-1:CNT_W];

  always_comb begin
    if (ovr_load_i)                      op = OP_OVR;
    else if (load_i)                     op = OP_LOAD;
    else if (test_dec_i || test_nodec_i) op = OP_TEST;
    else if (pop_i)                      op = OP_POP;
    else                                 op = OP_HOLD;
  end

  assign push    = (op == OP_LOAD) && vld;
  assign pop_req = ((op == OP_TEST) && ce_o) || (op == OP_POP);

  loop_cnt_reg #(.W(CNT_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .dec_i      (test_dec_i),
    .load_val_i (data_i[CNT_W-1:0]),
    .stk_top_i  (stk_top),
    .stk_empty_i(stk_empty_o),
    .cnt_o      (cnt),
    .vld_o      (vld),
    .ce_o       (ce_o)
  );

  loop_cnt_stack #(.W(CNT_W), .DEPTH(DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop_req),
    .din_i  (cnt),
    .top_o  (stk_top),
    .empty_o(stk_empty_o),
    .ovf_o  (stk_ovf_o)
  );

  assign rd_data_o = {{PAD_W{1'b0}}, cnt};
endmodule

// File: rtl/loop_cnt_chk.sv
module loop_cnt_chk #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned BUS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [BUS_W-1:0] data_i,
  input logic             load_i,
  input logic             ovr_load_i,
  input logic             test_dec_i,
  input logic             test_nodec_i,
  input logic             pop_i,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             ce_o,
  input logic             stk_empty_o,
  input logic             stk_ovf_o
);
  logic any_load, only_pop;
  assign any_load = load_i || ovr_load_i;
  assign only_pop = pop_i && !any_load && !test_dec_i && !test_nodec_i;

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_load |=> rd_data_o == {{(BUS_W-CNT_W){1'b0}}, $past(data_i[CNT_W-1:0])}); // R1
  AST_CE_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> rd_data_o == BUS_W'(1)); // R2
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_dec_i && !any_load && !ce_o && rd_data_o != '0) |=> rd_data_o == $past(rd_data_o) - BUS_W'(1)); // R3
  AST_NODEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_nodec_i && !test_dec_i && !any_load && !ce_o) |=> $stable(rd_data_o)); // R3
  AST_READ_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BUS_W-1:CNT_W] == '0); // R4
  AST_EMPTY_POP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_pop && stk_empty_o) |=> (!ce_o && rd_data_o == $past(rd_data_o))); // R7
  AST_OVR_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_load_i |=> ($stable(stk_empty_o) && $stable(stk_ovf_o))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_ovf_o |=> stk_ovf_o); // R11
endmodule

bind loop_cnt_top loop_cnt_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/loop_cnt_top_tb_top.sv
`timescale 1ns/1ps
module loop_cnt_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        load_i = 0, ovr_load_i = 0, test_dec_i = 0, test_nodec_i = 0, pop_i = 0;
  logic [15:0] rd_data_o;
  logic        ce_o, stk_empty_o, stk_ovf_o;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model
  int m_cnt = 0;
  bit m_vld = 0;
  bit m_ovf = 0;
  int m_q[$];

  always #10 clk_i = ~clk_i; // 50 MHz

  loop_cnt_top dut_i (.*);

  function automatic bit m_ce();
    return m_vld && (m_cnt == 1);
  endfunction

  function automatic void m_push(int v);
    if (m_q.size() == 4) begin
      void'(m_q.pop_front());
      m_ovf = 1;
    end
    m_q.push_back(v);
  endfunction

  function automatic void m_update(bit ld, bit ov, bit td, bit tn, bit pp, int d);
    if (ov) begin
      m_cnt = d & 16'h3FFF; m_vld = 1;
    end else if (ld) begin
      if (m_vld) m_push(m_cnt);
      m_cnt = d & 16'h3FFF; m_vld = 1;
    end else if (td || tn) begin
      if (m_ce()) begin
        if (m_q.size() > 0) begin
          m_cnt = m_q.pop_back(); m_vld = 1;
        end else begin
          m_vld = 0;
          if (td) m_cnt = m_cnt - 1;
        end
      end else if (td && m_cnt != 0) begin
        m_cnt = m_cnt - 1;
      end
    end else if (pp) begin
      if (m_q.size() > 0) begin
        m_cnt = m_q.pop_back(); m_vld = 1;
      end else begin
        m_vld = 0;
      end
    end
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int act, exp;
    act = {rd_data_o, ce_o, stk_empty_o, stk_ovf_o};
    exp = {m_cnt[15:0], m_ce(), m_q.size() == 0, m_ovf};
    chk(tag, act, exp);
  endtask

  task automatic step(input string tag, input bit ld, ov, td, tn, pp, input logic [15:0] d);
    @(negedge clk_i);
    compare(tag);
    load_i = ld; ovr_load_i = ov; test_dec_i = td; test_nodec_i = tn; pop_i = pp; data_i = d;
    @(posedge clk_i);
    m_update(ld, ov, td, tn, pp, int'(d));
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 16'h0);
  endtask

  // sample just after the edge that step applied
  task automatic expect_rd(input string tag, input int exp);
    #1 chk(tag, int'(rd_data_o), exp);
  endtask

  task automatic expect_ce(input string tag, input bit exp);
    #1 chk(tag, int'(ce_o), int'(exp));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9", {rd_data_o, ce_o, stk_empty_o, stk_ovf_o}, {16'h0, 1'b0, 1'b1, 1'b0});
    rst_ni = 1'b1;

    // R1, R2, R3: loop of 3 with decrementing tests; R8: first load does not push
    step("R1", 1, 0, 0, 0, 0, 16'd3);
    expect_rd("R1", 3);
    idle("R8");
    chk("R8", int'(stk_empty_o), 1);
    step("R3", 0, 0, 1, 0, 0, 0);
    expect_rd("R3", 2);
    step("R3", 0, 0, 0, 1, 0, 0);
    expect_rd("R3", 2);
    step("R3", 0, 0, 1, 0, 0, 0);
    expect_ce("R2", 1);
    // R6: expired test with empty stack invalidates and decrements
    step("R6", 0, 0, 1, 0, 0, 0);
    expect_rd("R6", 0);
    expect_ce("R6", 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    expect_rd("R3", 0);
    // R8: counter invalid, load does not push
    step("R8", 1, 0, 0, 0, 0, 16'd5);
    idle("R8");
    chk("R8", int'(stk_empty_o), 1);

    // R5, R6: nesting
    step("R5", 1, 0, 0, 0, 0, 16'd1);
    idle("R5");
    chk("R5", int'(stk_empty_o), 0);
    chk("R2", int'(ce_o), 1);
    step("R6", 0, 0, 0, 1, 0, 0);
    expect_rd("R6", 5);
    expect_ce("R6", 0);
    chk("R9", int'(stk_empty_o), 1);

    // R4: upper bus bits ignored, read pads with zero
    step("R4", 0, 1, 0, 0, 0, 16'hFFFF);
    expect_rd("R4", 16'h3FFF);
    idle("R4");
    idle("R4");
    expect_rd("R4", 16'h3FFF);

    // R10: overwrite never pushes and wins over load
    step("R10", 1, 1, 0, 0, 0, 16'd9);
    idle("R10");
    chk("R10", int'(stk_empty_o), 1);
    expect_rd("R10", 9);

    // R11, R5: five pushes onto four slots
    step("R11", 1, 0, 0, 0, 0, 16'd10);
    step("R11", 1, 0, 0, 0, 0, 16'd11);
    step("R11", 1, 0, 0, 0, 0, 16'd12);
    step("R11", 1, 0, 0, 0, 0, 16'd13);
    idle("R11");
    chk("R11", int'(stk_ovf_o), 0);
    step("R11", 1, 0, 0, 0, 0, 16'd14);
    expect_rd("R11", 14);
    idle("R11");
    chk("R11", int'(stk_ovf_o), 1);
    // R7: unwind in LIFO order; 9 was dropped
    step("R7", 0, 0, 0, 0, 1, 0);
    expect_rd("R7", 13);
    step("R7", 0, 0, 0, 0, 1, 0);
    expect_rd("R7", 12);
    step("R7", 0, 0, 0, 0, 1, 0);
    expect_rd("R7", 11);
    step("R7", 0, 0, 0, 0, 1, 0);
    expect_rd("R7", 10);
    step("R7", 0, 0, 0, 0, 1, 0);
    expect_rd("R7", 10);
    chk("R9", int'(stk_empty_o), 1);
    // R8: invalid after empty pop, no push
    step("R8", 1, 0, 0, 0, 0, 16'd2);
    idle("R8");
    chk("R8", int'(stk_empty_o), 1);
    chk("R11", int'(stk_ovf_o), 1);

    // R1: load wins over test and pop
    step("R1", 1, 0, 1, 0, 1, 16'd7);
    expect_rd("R1", 7);
    // R3: both test strobes, decrement applies
    step("R3", 0, 0, 1, 1, 0, 0);
    expect_rd("R3", 6);

    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      int r;
      bit ld, ov, td, tn, pp;
      r  = int'($urandom_range(0, 99));
      ld = (r < 15);
      ov = (r >= 95);
      td = (r >= 15 && r < 60);
      tn = (r >= 60 && r < 70);
      pp = (r >= 70 && r < 80);
      step("R6", ld, ov, td, tn, pp, 16'($urandom_range(0, 4)) | 16'($urandom_range(0, 3) << 14));
    end
    idle("R6");
    finish_run();
  end
endmodule